// File: doc/BRIEF.md
# Keyed Control Register File

A bank of 32-bit system control words behind a simple byte-addressed read/write bus that accepts only aligned word accesses. Word 0 holds an unlock flag. Writing the unlock constant sets the flag. Any other value clears it. While the flag is clear, every write except a write to word 0 is refused.

Reset and clock-stop control words accumulate bits. A write ORs data into them. A companion alias one word higher clears the bits written as 1. Two strap words work the same way, and each has a protect word two words above it that can freeze further set writes. The bank also provides:
- read-only revision and identity words,
- PLL extension words that always read back with the lock bit high,
- a pseudo-random port that advances on every read.

Bus reads return their data one cycle after the request. A one-cycle error pulse marks every refused access. Reset loads built-in defaults, together with the strap words, the second revision word and the unlock flag taken from input ports.

Top module: `keyed_ctrl_regs`

## Requirements
- R1: A synchronous reset loads the following values:
  - byte 0x00: unlock flag from `key_in`
  - 0x04: `REV_FIXED`
  - 0x08: `rev_in`
  - 0x40 and 0x50: `strap0_in` and `strap1_in`
  - 0x20: 0xF7C3FED8
  - 0x28: 0x0DFFFFFC
  - 0x30: 0xFFFF7F8A
  - 0x38: 0xFFF0FFF0
  - 0x0C: 0x1234ABCD
  - 0x10: 0x88884444
  - 0x60: 0x1000408F
  - 0x68: 0x1008405F
  - 0x70: 0x1004077F
  - every other word: 0
- R2: A write to byte 0x00 stores 1 if the data equals `UNLOCK_KEY` and 0 otherwise. A read of 0x00 returns that flag in bit 0, with zeros above it.
- R3: While the flag is 0, a write to any other word is dropped and pulses `bus_err`. Reads are unaffected by the flag.
- R4: A write to a set word (0x20, 0x28, 0x30, 0x38) ORs the data into that word and never clears a bit.
- R5: A write to the alias one word above a set word or strap word (0x24, 0x2C, 0x34, 0x3C, 0x44, 0x54) clears, in the word below, the bits that are 1 in the data. A read of an alias returns 0.
- R6: The strap words 0x40 and 0x50 OR in written data, like set words. While the protect word two words above (0x48 or 0x58) is nonzero, such a set write is dropped with `bus_err`. Its clear alias still works.
- R7: A read of the PLL extension words 0x64, 0x6C and 0x74 returns the stored value with bit 31 forced to 1.
- R8: Each read of 0x14 first advances a 32-bit Galois LFSR and then returns the new state. One step shifts the state right by one and XORs in `LFSR_TAPS` (0x80200003) when the bit shifted out was 1. Reset reloads the LFSR with `LFSR_SEED` (default 1).
- R9: Writes to 0x04, 0x08, 0x0C, 0x10 and 0x14 are dropped with `bus_err`. A write to 0x14 does not advance the LFSR.
- R10: An access with nonzero address bits [1:0], or to a word at or beyond `NUM_WORDS`, pulses `bus_err`. A read of such an address returns 0, and a write to it changes nothing.
- R11: `bus_rdata` changes only in the cycle after a read request and holds otherwise. `bus_err` is high for exactly the cycle after the offending request.
- R12: Every other word below `NUM_WORDS` (for example 0x18, 0x1C, 0x4C, 0x5C, 0x78, 0x7C, the protect words and the PLL parameter words) reads back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_in | input | 1 | Unlock flag value loaded at reset |
| strap0_in | input | 32 | Strap word 0 value loaded at reset |
| strap1_in | input | 32 | Strap word 1 value loaded at reset |
| rev_in | input | 32 | Second revision word value loaded at reset |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | One-cycle pulse on a refused access |

## Verification
Most faults in the stored words stay invisible until the affected word is read. They then show on `bus_rdata` one cycle after the read request, so the bench reads each touched word back right after changing it.

Some faults show sooner or in a different place:
- A wrong unlock flag or protect decision shows on `bus_err` in the cycle right after the write, before any read.
- An LFSR that skipped or repeated a step shows only on the next read of the random port, and every later value in the sequence is then also wrong.

// File: rtl/kcr_pkg.sv
package kcr_pkg;

  typedef enum logic [3:0] {
    K_BAD, K_KEY, K_RO, K_RNG, K_SET, K_CLR, K_STRAP, K_PLLEXT, K_PLAIN
  } kind_t;

  // word indices (byte offset = index * 4)
  localparam int W_KEY    = 0;
  localparam int W_REVA   = 1;
  localparam int W_REVB   = 2;
  localparam int W_CHIP0  = 3;
  localparam int W_CHIP1  = 4;
  localparam int W_RNG    = 5;
  localparam int W_RST0   = 8;
  localparam int W_RST1   = 10;
  localparam int W_CLK0   = 12;
  localparam int W_CLK1   = 14;
  localparam int W_STRAP0 = 16;
  localparam int W_PROT0  = W_STRAP0 + 2;
  localparam int W_STRAP1 = 20;
  localparam int W_PROT1  = W_STRAP1 + 2;
  localparam int W_PLLA   = 24;
  localparam int W_PLLB   = 26;
  localparam int W_PLLC   = 28;
  localparam int MAP_WORDS = 30;

  function automatic kind_t word_kind(input int w);
    kind_t k;
    case (w)
      W_KEY:                                  k = K_KEY;
      W_REVA, W_REVB, W_CHIP0, W_CHIP1:       k = K_RO;
      W_RNG:                                  k = K_RNG;
      W_RST0, W_RST1, W_CLK0, W_CLK1:         k = K_SET;
      W_RST0 + 1, W_RST1 + 1, W_CLK0 + 1,
      W_CLK1 + 1, W_STRAP0 + 1, W_STRAP1 + 1: k = K_CLR;
      W_STRAP0, W_STRAP1:                     k = K_STRAP;
      W_PLLA + 1, W_PLLB + 1, W_PLLC + 1:     k = K_PLLEXT;
      default:                                k = K_PLAIN;
    endcase
    return k;
  endfunction

  function automatic logic [31:0] word_default(input int w);
    logic [31:0] v;
    case (w)
      W_RST0:  v = 32'hF7C3_FED8;
      W_RST1:  v = 32'h0DFF_FFFC;
      W_CLK0:  v = 32'hFFFF_7F8A;
      W_CLK1:  v = 32'hFFF0_FFF0;
      W_CHIP0: v = 32'h1234_ABCD;
      W_CHIP1: v = 32'h8888_4444;
      W_PLLA:  v = 32'h1000_408F;
      W_PLLB:  v = 32'h1008_405F;
      W_PLLC:  v = 32'h1004_077F;
      default: v = 32'h0;
    endcase
    return v;
  endfunction

  function automatic logic [31:0] lfsr_advance(input logic [31:0] s, input logic [31:0] taps);
    return s[0] ? ((s >> 1) ^ taps) : (s >> 1);
  endfunction

endpackage

// File: rtl/kcr_decode.sv
module kcr_decode
  import kcr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_WORDS = 32,
  parameter int WI_W      = $clog2(NUM_WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output kind_t             kind,
  output logic [WI_W-1:0]   widx
);
  logic [ADDR_W-3:0] word;
  logic              in_range;

  assign word     = addr[ADDR_W-1:2];
  assign in_range = (addr[1:0] == 2'b00) && (32'(word) < 32'(NUM_WORDS));
  assign widx     = word[WI_W-1:0];
  assign kind     = in_range ? word_kind(int'(32'(word))) : K_BAD;
endmodule

// File: rtl/kcr_lfsr.sv
module kcr_lfsr
  import kcr_pkg::*;
#(
  parameter logic [31:0] SEED = 32'h0000_0001,
  parameter logic [31:0] TAPS = 32'h8020_0003
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        step,
  output logic [31:0] next_state
);
  logic [31:0] state_q;

  assign next_state = lfsr_advance(state_q, TAPS);

  always_ff @(posedge clk) begin
    if (rst)       state_q <= SEED;
    else if (step) state_q <= next_state;
  end

  // R8: a maximal-length register never reaches the all-zero lockup state
  assert_lfsr_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
    state_q != 32'h0);
endmodule

// File: rtl/kcr_store.sv
module kcr_store
  import kcr_pkg::*;
#(
  parameter int          NUM_WORDS  = 32,
  parameter int          WI_W       = $clog2(NUM_WORDS),
  parameter logic [31:0] UNLOCK_KEY = 32'h5EC0_1A7E,
  parameter logic [31:0] REV_FIXED  = 32'hA501_0003
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            key_in,
  input  logic [31:0]     strap0_in,
  input  logic [31:0]     strap1_in,
  input  logic [31:0]     rev_in,
  input  logic            wr,
  input  kind_t           kind,
  input  logic [WI_W-1:0] widx,
  input  logic [31:0]     wdata,
  output logic [31:0]     regs_q [NUM_WORDS],
  output logic            wr_drop
);
  logic unlocked;
  logic prot_nz;
  logic wr_stb;

  assign unlocked = regs_q[W_KEY][0];
  assign prot_nz  = (widx == WI_W'(W_STRAP0)) ? (regs_q[W_PROT0] != 32'h0)
                                              : (regs_q[W_PROT1] != 32'h0);
  assign wr_drop  = (kind == K_BAD) || (kind == K_RO) || (kind == K_RNG) ||
                    ((kind != K_KEY) && !unlocked) ||
                    ((kind == K_STRAP) && prot_nz);
  assign wr_stb   = wr && !wr_drop;

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    localparam kind_t KI        = word_kind(i);
    localparam bit    CLR_ABOVE = (i + 1 < NUM_WORDS) && (word_kind(i + 1) == K_CLR);
    logic [31:0] q;

    always_ff @(posedge clk) begin
      if (rst) begin
        if (i == W_KEY)         q <= {31'b0, key_in};
        else if (i == W_REVA)   q <= REV_FIXED;
        else if (i == W_REVB)   q <= rev_in;
        else if (i == W_STRAP0) q <= strap0_in;
        else if (i == W_STRAP1) q <= strap1_in;
        else                    q <= word_default(i);
      end else if (wr_stb) begin
        if (widx == WI_W'(i)) begin
          if (KI == K_KEY)                         q <= {31'b0, (wdata == UNLOCK_KEY)};
          else if (KI == K_SET || KI == K_STRAP)   q <= q | wdata;
          else if (KI == K_PLAIN || KI == K_PLLEXT) q <= wdata;
        end else if (CLR_ABOVE && (widx == WI_W'(i + 1))) begin
          q <= q & ~wdata;
        end
      end
    end

    assign regs_q[i] = q;
  end

  // R6: a set write to a protected strap word leaves it unchanged
  assert_strap_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    (wr && kind == K_STRAP && widx == WI_W'(W_STRAP0) && regs_q[W_PROT0] != 32'h0)
    |=> $stable(regs_q[W_STRAP0]));

  // R4: a set write never clears a bit of reset control word 0
  assert_set_keeps_bits_R4: assert property (@(posedge clk) disable iff (rst)
    (wr && kind == K_SET && widx == WI_W'(W_RST0))
    |=> ((regs_q[W_RST0] & $past(regs_q[W_RST0])) == $past(regs_q[W_RST0])));
endmodule

// File: rtl/keyed_ctrl_regs.sv
module keyed_ctrl_regs
  import kcr_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          NUM_WORDS  = 32,
  parameter logic [31:0] UNLOCK_KEY = 32'h5EC0_1A7E,
  parameter logic [31:0] REV_FIXED  = 32'hA501_0003,
  parameter logic [31:0] LFSR_SEED  = 32'h0000_0001,
  parameter logic [31:0] LFSR_TAPS  = 32'h8020_0003
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_in,
  input  logic [31:0]       strap0_in,
  input  logic [31:0]       strap1_in,
  input  logic [31:0]       rev_in,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err
);
  localparam int WI_W = $clog2(NUM_WORDS);

  kind_t           dec_kind;
  logic [WI_W-1:0] widx;
  logic [31:0]     regs [NUM_WORDS];
  logic            wr_drop;
  logic [31:0]     rng_next;
  logic [31:0]     rd_val;

  kcr_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .WI_W(WI_W)) u_dec (
    .addr(bus_addr), .kind(dec_kind), .widx(widx)
  );

  kcr_store #(.NUM_WORDS(NUM_WORDS), .WI_W(WI_W), .UNLOCK_KEY(UNLOCK_KEY),
              .REV_FIXED(REV_FIXED)) u_store (
    .clk(clk), .rst(rst), .key_in(key_in), .strap0_in(strap0_in),
    .strap1_in(strap1_in), .rev_in(rev_in), .wr(bus_wr), .kind(dec_kind),
    .widx(widx), .wdata(bus_wdata), .regs_q(regs), .wr_drop(wr_drop)
  );

  kcr_lfsr #(.SEED(LFSR_SEED), .TAPS(LFSR_TAPS)) u_rng (
    .clk(clk), .rst(rst), .step(bus_rd && dec_kind == K_RNG), .next_state(rng_next)
  );

  always_comb begin
    case (dec_kind)
      K_BAD:    rd_val = 32'h0;
      K_CLR:    rd_val = 32'h0;
      K_RNG:    rd_val = rng_next;
      K_PLLEXT: rd_val = regs[widx] | 32'h8000_0000;
      default:  rd_val = regs[widx];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= 32'h0;
      bus_err   <= 1'b0;
    end else begin
      bus_err <= (bus_wr && wr_drop) || (bus_rd && dec_kind == K_BAD);
      if (bus_rd) bus_rdata <= rd_val;
    end
  end

  // R9: a write to a read-only word is reported
  assert_ro_write_err_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && dec_kind == K_RO) |=> bus_err);

  // R3: a write to a plain word while locked is reported
  assert_locked_write_err_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && dec_kind == K_PLAIN && !regs[W_KEY][0]) |=> bus_err);

  // R7: PLL extension reads carry the lock bit
  assert_pll_lock_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && dec_kind == K_PLLEXT) |=> bus_rdata[31]);

  // R10: bad-address reads return zero and flag an error
  assert_bad_read_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && dec_kind == K_BAD) |=> (bus_rdata == 32'h0 && bus_err));

  // R2: the unlock word reads as a single flag bit
  assert_key_flag_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && dec_kind == K_KEY) |=> (bus_rdata[31:1] == 31'h0));

  // R11: read data holds when no read is requested
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/keyed_ctrl_regs_test.sv
module keyed_ctrl_regs_test;
  localparam logic [31:0] KEY  = 32'h5EC0_1A7E;
  localparam logic [31:0] REVF = 32'hA501_0003;
  localparam logic [31:0] SEED = 32'h0000_0001;
  localparam logic [31:0] TAPS = 32'h8020_0003;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        key_in = 1'b0;
  logic [31:0] strap0_in = 32'h0000_00F0;
  logic [31:0] strap1_in = 32'h1200_0034;
  logic [31:0] rev_in = 32'h0BAD_0002;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = 8'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        bus_err;

  int nchk = 0;
  int nerr = 0;
  logic [31:0] d;
  logic        e;

  always #5 clk = ~clk;

  keyed_ctrl_regs uut (
    .clk(clk), .rst(rst), .key_in(key_in), .strap0_in(strap0_in),
    .strap1_in(strap1_in), .rev_in(rev_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err)
  );

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s[0] ? ((s >> 1) ^ TAPS) : (s >> 1);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_word(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    e = bus_err; bus_wr = 1'b0;
  endtask

  task automatic rd_word(input logic [7:0] a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata; e = bus_err; bus_rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] exp;
    logic [31:0] rng;
    logic [31:0] setdef [4];
    logic [7:0]  setadr [4];
    setdef[0] = 32'hF7C3_FED8; setdef[1] = 32'h0DFF_FFFC;
    setdef[2] = 32'hFFFF_7F8A; setdef[3] = 32'hFFF0_FFF0;
    setadr[0] = 8'h20; setadr[1] = 8'h28; setadr[2] = 8'h30; setadr[3] = 8'h38;

    do_reset();
    // R1: reset contents
    rd_word(8'h00); check("R1 key flag", d, 32'h0);
    rd_word(8'h04); check("R1 rev fixed", d, REVF);
    rd_word(8'h08); check("R1 rev input", d, rev_in);
    rd_word(8'h40); check("R1 strap0", d, strap0_in);
    rd_word(8'h50); check("R1 strap1", d, strap1_in);
    rd_word(8'h0C); check("R1 chip0", d, 32'h1234_ABCD);
    rd_word(8'h10); check("R1 chip1", d, 32'h8888_4444);
    rd_word(8'h60); check("R1 pll a", d, 32'h1000_408F);
    rd_word(8'h68); check("R1 pll b", d, 32'h1008_405F);
    rd_word(8'h70); check("R1 pll c", d, 32'h1004_077F);
    rd_word(8'h48); check("R1 prot0", d, 32'h0);
    for (int i = 0; i < 4; i++) begin
      rd_word(setadr[i]); check("R1 set default", d, setdef[i]);
    end
    check("R11 no err on good read", {31'b0, e}, 32'h0);

    // R11: data holds, err lasts one cycle
    rd_word(8'h80);
    check("R11 err pulse", {31'b0, e}, 32'h1);
    @(negedge clk);
    check("R11 err drops", {31'b0, bus_err}, 32'h0);
    rd_word(8'h0C);
    repeat (2) @(negedge clk);
    check("R11 rdata held", bus_rdata, 32'h1234_ABCD);

    // R3: locked writes refused
    wr_word(8'h18, 32'hDEAD_BEEF); check("R3 locked write err", {31'b0, e}, 32'h1);
    rd_word(8'h18); check("R3 locked word unchanged", d, 32'h0);
    wr_word(8'h24, 32'hFFFF_FFFF); check("R3 locked clear err", {31'b0, e}, 32'h1);
    rd_word(8'h20); check("R3 locked clear no effect", d, setdef[0]);

    // R2: key handling
    wr_word(8'h00, KEY ^ 32'h1); check("R2 key write no err", {31'b0, e}, 32'h0);
    rd_word(8'h00); check("R2 wrong key", d, 32'h0);
    wr_word(8'h00, KEY);
    rd_word(8'h00); check("R2 right key", d, 32'h1);

    // R12: plain words
    for (int i = 0; i < 6; i++) begin
      logic [7:0] pa [6];
      pa[0] = 8'h18; pa[1] = 8'h1C; pa[2] = 8'h4C; pa[3] = 8'h5C; pa[4] = 8'h78; pa[5] = 8'h7C;
      wr_word(pa[i], 32'h1357_9BDF * (i + 3));
      rd_word(pa[i]); check("R12 plain readback", d, 32'h1357_9BDF * (i + 3));
    end
    wr_word(8'h60, 32'h0000_5A5A);
    rd_word(8'h60); check("R12 pll param rw", d, 32'h0000_5A5A);

    // R4 / R5: set and clear sweeps
    for (int r = 0; r < 4; r++) begin
      exp = setdef[r];
      for (int k = 0; k < 4; k++) begin
        wr_word(setadr[r], 32'h1111_1111 << k);
        exp = exp | (32'h1111_1111 << k);
        rd_word(setadr[r]); check("R4 set accumulates", d, exp);
        wr_word(setadr[r] + 8'h4, 32'hF00F_0000 >> (k * 4));
        exp = exp & ~(32'hF00F_0000 >> (k * 4));
        rd_word(setadr[r]); check("R5 clear alias", d, exp);
      end
      rd_word(setadr[r] + 8'h4); check("R5 alias reads zero", d, 32'h0);
    end

    // R6: strap protection
    exp = strap0_in;
    wr_word(8'h40, 32'h0F00_0000); exp = exp | 32'h0F00_0000;
    rd_word(8'h40); check("R6 strap set", d, exp);
    wr_word(8'h48, 32'h1);
    wr_word(8'h40, 32'h0000_000F); check("R6 protected err", {31'b0, e}, 32'h1);
    rd_word(8'h40); check("R6 protected unchanged", d, exp);
    wr_word(8'h44, 32'h0000_00F0); check("R6 clear no err", {31'b0, e}, 32'h0);
    exp = exp & ~32'h0000_00F0;
    rd_word(8'h40); check("R6 clear under protect", d, exp);
    wr_word(8'h50, 32'h0000_0100);
    rd_word(8'h50); check("R6 strap1 independent", d, strap1_in | 32'h0000_0100);
    wr_word(8'h58, 32'h8000_0000);
    wr_word(8'h50, 32'h0000_0001); check("R6 strap1 protected err", {31'b0, e}, 32'h1);
    wr_word(8'h48, 32'h0);
    wr_word(8'h40, 32'h0000_0003); exp = exp | 32'h3;
    rd_word(8'h40); check("R6 unprotected again", d, exp);

    // R7: PLL lock bit
    wr_word(8'h64, 32'h0000_1234);
    rd_word(8'h64); check("R7 pll a lock", d, 32'h8000_1234);
    rd_word(8'h6C); check("R7 pll b lock", d, 32'h8000_0000);
    wr_word(8'h74, 32'h8000_00AB);
    rd_word(8'h74); check("R7 pll c lock", d, 32'h8000_00AB);

    // R8: LFSR sequence
    rng = SEED;
    for (int k = 0; k < 6; k++) begin
      rng = nxt(rng);
      rd_word(8'h14); check("R8 rng value", d, rng);
    end

    // R9: read-only words
    wr_word(8'h14, 32'hFFFF_FFFF); check("R9 rng write err", {31'b0, e}, 32'h1);
    rng = nxt(rng);
    rd_word(8'h14); check("R9 rng not advanced by write", d, rng);
    wr_word(8'h04, 32'h0); check("R9 rev write err", {31'b0, e}, 32'h1);
    rd_word(8'h04); check("R9 rev unchanged", d, REVF);
    wr_word(8'h08, 32'h0);
    rd_word(8'h08); check("R9 rev2 unchanged", d, rev_in);
    wr_word(8'h0C, 32'h0); check("R9 chip write err", {31'b0, e}, 32'h1);
    rd_word(8'h0C); check("R9 chip0 unchanged", d, 32'h1234_ABCD);
    wr_word(8'h10, 32'h0);
    rd_word(8'h10); check("R9 chip1 unchanged", d, 32'h8888_4444);

    // R10: bad addresses
    rd_word(8'hFC); check("R10 oob read zero", d, 32'h0);
    check("R10 oob read err", {31'b0, e}, 32'h1);
    rd_word(8'h19); check("R10 misaligned read zero", d, 32'h0);
    check("R10 misaligned read err", {31'b0, e}, 32'h1);
    wr_word(8'h1A, 32'hCAFE_F00D); check("R10 misaligned write err", {31'b0, e}, 32'h1);
    rd_word(8'h18); check("R10 misaligned write ignored", d, 32'h1357_9BDF * 3);
    wr_word(8'h84, 32'h1); check("R10 oob write err", {31'b0, e}, 32'h1);

    // R1 / R8: second reset with other inputs
    key_in = 1'b1; strap0_in = 32'hA5A5_0000; rev_in = 32'h0000_0777;
    do_reset();
    rd_word(8'h00); check("R1 key flag from input", d, 32'h1);
    rd_word(8'h40); check("R1 strap0 reload", d, 32'hA5A5_0000);
    rd_word(8'h20); check("R1 set word reload", d, setdef[0]);
    rd_word(8'h18); check("R1 plain word cleared", d, 32'h0);
    rd_word(8'h14); check("R8 rng reseeded", d, nxt(SEED));

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule